// File: doc/BRIEF.md
# Routed level interrupt controller

This block takes thirty-two level-sensitive interrupt sources and fans them out to sixteen outputs. The outputs form a grid of four cores by four request lines per core. Each source owns one routing byte. The low nibble of that byte names the cores the source reaches, and the high nibble names the request lines it reaches. A single enable mask gates every source. Software changes that mask only by writing ones to a set word or to a clear word, so no read-modify-write sequence is ever needed.

Nothing is latched. The pending state is always the live input levels ANDed with the enable mask. That state can be read as one global word, or filtered for each core through that core's routing bit. An output (core c, line y) goes high when core c has any pending source and, judged separately, line y has any pending source. The two conditions need not come from the same source.

The register bus accepts byte accesses to the routing bytes and aligned 32-bit accesses elsewhere. Strobes are single-cycle. Read data is registered.

Top module: `lvl_irq_router`

## Requirements
- R1: The global pending word at offset 0x20 (aligned word read) equals irq_i AND the enable mask, sampled at the read. It follows the inputs with no latching, so it drops as soon as the input drops.
- R2: The routing byte of source s sits at offset s (0x00..0x1F) and is accessed only with size_word_i=0. Bits 3:0 select cores 0..3 and bits 7:4 select lines 0..3. A byte read returns the stored byte in rdata_o[7:0], with the upper bits zero.
- R3: A word write to 0x28 ORs wdata_i into the enable mask.
- R4: A word write to 0x2C clears every enable bit where wdata_i is 1 and leaves the other bits unchanged.
- R5: A word read of 0x24 returns the enable mask.
- R6: A word read of 0x40+8*c (c=0..3) returns the pending sources whose routing bit c is set.
- R7: irq_o[4*c+y] is high exactly when core c's pending word is nonzero and some pending source has line bit y set. The two conditions are evaluated independently of each other.
- R8: The following accesses are ignored, and reads of them return zero: byte accesses at offsets of 0x20 and above, word accesses that are not 4-byte aligned, word accesses inside the routing window, word accesses in the per-core window that are not 8-byte aligned, and accesses to unmapped offsets.
- R9: Writes to 0x20, 0x24 and the per-core pending words change no state and no output.
- R10: After reset every routing byte, the enable mask, irq_o and rdata_o are zero.
- R11: irq_o reflects the inputs and registers one clock edge after they change. rdata_o is valid after the edge that samples rd_i and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32 | Level interrupt sources |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data (bits 7:0 for byte writes) |
| size_word_i | input | 1 | 1 = 32-bit access, 0 = byte access |
| rd_i | input | 1 | Single-cycle read strobe |
| wr_i | input | 1 | Single-cycle write strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 16 | Routed outputs, index 4*core+line |

## Verification
Register writes take effect at the edge that samples the strobe, so irq_o reflects a write at the second edge after the strobe is driven. An input change shows on irq_o at the first edge after it is applied. Read data is captured at the edge that samples rd_i. The bench drives every stimulus on a falling edge. Before the due edge, it checks that irq_o still holds its old value. It then takes the new value on the falling edge that follows the due edge, so every check lands on the cycle named in R11.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int OFS_PEND     = 'h20;
  localparam int OFS_EN       = 'h24;
  localparam int OFS_EN_SET   = 'h28;
  localparam int OFS_EN_CLR   = 'h2C;
  localparam int OFS_CORE     = 'h40;
  localparam int CORE_STRIDE  = 8;
endpackage

// File: rtl/lir_regfile.sv
module lir_regfile
  import lvl_irq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NLINE = 4,
  parameter int AW    = 8,
  localparam int RW   = NCORE + NLINE
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [AW-1:0]              addr_i,
  input  logic [31:0]                wdata_i,
  input  logic                       size_word_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [NSRC-1:0]            glob_pend_i,
  input  logic [NCORE-1:0][NSRC-1:0] core_pend_i,
  output logic [NSRC-1:0][RW-1:0]    route_o,
  output logic [NSRC-1:0]            en_o,
  output logic [31:0]                rdata_o
);
  logic [NSRC-1:0][RW-1:0] route_q;
  logic [NSRC-1:0]         en_q;
  logic [31:0]             rdata_q, rd_val;
  logic                    hit_route, word_ok;
  int                      a_int;

  assign a_int     = int'(addr_i);
  assign hit_route = !size_word_i && (a_int < NSRC);
  assign word_ok   = size_word_i && (addr_i[1:0] == 2'b00);

  always_comb begin
    rd_val = '0;
    if (hit_route) begin
      rd_val[RW-1:0] = route_q[addr_i[$clog2(NSRC)-1:0]];
    end else if (word_ok) begin
      if (a_int == OFS_PEND) rd_val[NSRC-1:0] = glob_pend_i;
      if (a_int == OFS_EN)   rd_val[NSRC-1:0] = en_q;
      for (int c = 0; c < NCORE; c++) begin
        if (a_int == OFS_CORE + CORE_STRIDE * c) rd_val[NSRC-1:0] = core_pend_i[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (rd_i) rdata_q <= rd_val;
      if (wr_i && hit_route) route_q[addr_i[$clog2(NSRC)-1:0]] <= wdata_i[RW-1:0];
      if (wr_i && word_ok && a_int == OFS_EN_SET) en_q <= en_q | wdata_i[NSRC-1:0];
      if (wr_i && word_ok && a_int == OFS_EN_CLR) en_q <= en_q & ~wdata_i[NSRC-1:0];
    end
  end

  assign route_o = route_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/lir_pend_calc.sv
module lir_pend_calc #(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NLINE = 4,
  localparam int RW   = NCORE + NLINE
) (
  input  logic [NSRC-1:0]            irq_i,
  input  logic [NSRC-1:0]            en_i,
  input  logic [NSRC-1:0][RW-1:0]    route_i,
  output logic [NSRC-1:0]            glob_pend_o,
  output logic [NCORE-1:0][NSRC-1:0] core_pend_o,
  output logic [NLINE-1:0]           line_hit_o
);
  assign glob_pend_o = irq_i & en_i;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign core_pend_o[c][s] = glob_pend_o[s] & route_i[s][c];
    end
  end

  for (genvar y = 0; y < NLINE; y++) begin : g_line
    logic [NSRC-1:0] col;
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign col[s] = glob_pend_o[s] & route_i[s][NCORE+y];
    end
    assign line_hit_o[y] = |col;
  end
endmodule

// File: rtl/lir_out_stage.sv
module lir_out_stage #(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NLINE = 4,
  localparam int NOUT = NCORE * NLINE
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NCORE-1:0][NSRC-1:0] core_pend_i,
  input  logic [NLINE-1:0]           line_hit_i,
  output logic [NOUT-1:0]            irq_o
);
  logic [NOUT-1:0] out_d, out_q;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar y = 0; y < NLINE; y++) begin : g_line
      assign out_d[NLINE*c+y] = (|core_pend_i[c]) & line_hit_i[y];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign irq_o = out_q;
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router #(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NLINE = 4,
  parameter int AW    = 8,
  localparam int RW   = NCORE + NLINE,
  localparam int NOUT = NCORE * NLINE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] irq_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            size_word_i,
  input  logic            rd_i,
  input  logic            wr_i,
  output logic [31:0]     rdata_o,
  output logic [NOUT-1:0] irq_o
);
  logic [NSRC-1:0][RW-1:0]    route_w;
  logic [NSRC-1:0]            en_w;
  logic [NSRC-1:0]            glob_pend_w;
  logic [NCORE-1:0][NSRC-1:0] core_pend_w;
  logic [NLINE-1:0]           line_hit_w;

  lir_regfile #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .size_word_i (size_word_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .glob_pend_i (glob_pend_w),
    .core_pend_i (core_pend_w),
    .route_o     (route_w),
    .en_o        (en_w),
    .rdata_o     (rdata_o)
  );

  lir_pend_calc #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE)) u_pend (
    .irq_i       (irq_i),
    .en_i        (en_w),
    .route_i     (route_w),
    .glob_pend_o (glob_pend_w),
    .core_pend_o (core_pend_w),
    .line_hit_o  (line_hit_w)
  );

  lir_out_stage #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_pend_i (core_pend_w),
    .line_hit_i  (line_hit_w),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/lvl_irq_router_chk.sv
module lvl_irq_router_chk
  import lvl_irq_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NLINE = 4,
  parameter int AW    = 8,
  localparam int NOUT = NCORE * NLINE
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NSRC-1:0]            irq_i,
  input logic [AW-1:0]              addr_i,
  input logic [31:0]                wdata_i,
  input logic                       size_word_i,
  input logic                       wr_i,
  input logic [NOUT-1:0]            irq_o,
  input logic [NSRC-1:0]            en_q,
  input logic [NSRC-1:0]            glob_pend,
  input logic [NCORE-1:0][NSRC-1:0] core_pend
);
  AST_PEND_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((glob_pend & ~en_q) == '0) && ((glob_pend & ~irq_i) == '0)); // R1

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_word_i && int'(addr_i) == OFS_EN_SET)
    |=> ((en_q & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0]))); // R3

  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_word_i && int'(addr_i) == OFS_EN_CLR)
    |=> ((en_q & $past(wdata_i[NSRC-1:0])) == '0)); // R4

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && size_word_i && (int'(addr_i) == OFS_EN_SET || int'(addr_i) == OFS_EN_CLR))
    |=> $stable(en_q)); // R9

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    AST_CORE_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_pend[c] & ~glob_pend) == '0); // R6
    for (genvar y = 0; y < NLINE; y++) begin : g_line
      AST_OUT_NEEDS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o[NLINE*c+y] |-> $past(|core_pend[c])); // R7
    end
  end
endmodule

bind lvl_irq_router lvl_irq_router_chk #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .size_word_i (size_word_i),
  .wr_i        (wr_i),
  .irq_o       (irq_o),
  .en_q        (en_w),
  .glob_pend   (glob_pend_w),
  .core_pend   (core_pend_w)
);

// File: tb/lvl_irq_router_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        size_w = 1'b0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] rdata;
  logic [15:0] irq_out;
  int          n_run = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  lvl_irq_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr), .wdata_i(wdata),
    .size_word_i(size_w), .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .irq_o(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic w, input logic [31:0] d);
    @(negedge clk); addr = a; size_w = w; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic w, output logic [31:0] d);
    @(negedge clk); addr = a; size_w = w; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R10 irq_o after reset", {16'b0, irq_out}, 32'h0);
    check("R10 rdata_o after reset", rdata, 32'h0);
    bus_rd(8'h24, 1'b1, d); check("R10 enable reset", d, 32'h0);
    bus_rd(8'h20, 1'b1, d); check("R10 pending with all inputs high", d, 32'h0);
    bus_rd(8'h05, 1'b0, d); check("R10 routing byte reset", d, 32'h0);
    irq = '0;
  endtask

  task automatic t_route;
    logic [31:0] d;
    bus_wr(8'h03, 1'b0, 32'hFFFF_FFA5);
    bus_rd(8'h03, 1'b0, d); check("R2 routing byte readback", d, 32'h0000_00A5);
    bus_rd(8'h00, 1'b1, d); check("R8 word read in routing window", d, 32'h0);
    bus_wr(8'h04, 1'b1, 32'h0000_00FF);
    bus_rd(8'h04, 1'b0, d); check("R8 word write in routing window ignored", d, 32'h0);
    bus_rd(8'h24, 1'b0, d); check("R8 byte read outside routing window", d, 32'h0);
    bus_wr(8'h03, 1'b0, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    bus_wr(8'h28, 1'b1, 32'h0000_00F0);
    bus_rd(8'h24, 1'b1, d); check("R3 R5 set then read", d, 32'h0000_00F0);
    bus_wr(8'h28, 1'b1, 32'h0000_000F);
    bus_rd(8'h24, 1'b1, d); check("R3 set accumulates", d, 32'h0000_00FF);
    bus_wr(8'h2C, 1'b1, 32'h0000_003C);
    bus_rd(8'h24, 1'b1, d); check("R4 clear selected bits", d, 32'h0000_00C3);
    bus_wr(8'h28, 1'b0, 32'h0000_00FF);
    bus_rd(8'h24, 1'b1, d); check("R8 byte write to set ignored", d, 32'h0000_00C3);
    bus_wr(8'h29, 1'b1, 32'hFFFF_FFFF);
    bus_rd(8'h24, 1'b1, d); check("R8 misaligned set ignored", d, 32'h0000_00C3);
    bus_wr(8'h24, 1'b1, 32'hFFFF_FFFF);
    bus_rd(8'h24, 1'b1, d); check("R9 write to enable read word ignored", d, 32'h0000_00C3);
  endtask

  task automatic t_pending;
    logic [31:0] d;
    irq = 32'h0000_0F0F;
    bus_rd(8'h20, 1'b1, d); check("R1 masked pending", d, 32'h0000_0003);
    bus_rd(8'h21, 1'b1, d); check("R8 misaligned read zero", d, 32'h0);
    irq = '0;
    bus_rd(8'h20, 1'b1, d); check("R1 no latching", d, 32'h0);
    bus_wr(8'h20, 1'b1, 32'hFFFF_FFFF);
    bus_rd(8'h20, 1'b1, d); check("R9 write to pending ignored", d, 32'h0);
    bus_rd(8'h60, 1'b1, d); check("R8 unmapped read zero", d, 32'h0);
  endtask

  task automatic t_outputs;
    logic [31:0] d;
    bus_wr(8'h28, 1'b1, 32'hFFFF_FFFF);
    bus_wr(8'h00, 1'b0, 32'h11);
    bus_wr(8'h05, 1'b0, 32'h42);
    @(negedge clk); irq = 32'h1;
    #1 check("R11 output not yet updated", {16'b0, irq_out}, 32'h0);
    @(negedge clk); check("R7 src0 core0 line0", {16'b0, irq_out}, 32'h0001);
    irq = 32'h20;
    @(negedge clk); check("R7 src5 core1 line2", {16'b0, irq_out}, 32'h0040);
    irq = 32'h21;
    @(negedge clk); check("R7 independent core and line terms", {16'b0, irq_out}, 32'h0055);
    bus_rd(8'h40, 1'b1, d); check("R6 core0 pending", d, 32'h1);
    bus_rd(8'h48, 1'b1, d); check("R6 core1 pending", d, 32'h20);
    bus_rd(8'h50, 1'b1, d); check("R6 core2 pending", d, 32'h0);
    bus_rd(8'h44, 1'b1, d); check("R8 per-core window off stride", d, 32'h0);
    bus_wr(8'h40, 1'b1, 32'hFFFF_FFFF);
    bus_rd(8'h40, 1'b1, d); check("R9 core pending write no effect", d, 32'h1);
    check("R9 outputs unchanged after core write", {16'b0, irq_out}, 32'h0055);
    bus_wr(8'h07, 1'b0, 32'h8C);
    @(negedge clk); irq = 32'h80;
    @(negedge clk); check("R7 multi-core route", {16'b0, irq_out}, 32'h8800);
    bus_rd(8'h58, 1'b1, d); check("R6 core3 pending", d, 32'h80);
    bus_wr(8'h2C, 1'b1, 32'h80);
    check("R11 output holds one cycle after write", {16'b0, irq_out}, 32'h8800);
    @(negedge clk); check("R4 disabled source drops outputs", {16'b0, irq_out}, 32'h0);
    bus_wr(8'h09, 1'b0, 32'h01);
    @(negedge clk); irq = 32'h200;
    @(negedge clk); check("R7 core pending without line", {16'b0, irq_out}, 32'h0);
    bus_rd(8'h40, 1'b1, d); check("R6 core0 sees line-less source", d, 32'h200);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    irq = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_enable();
    t_pending();
    t_outputs();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule